// File: doc/BRIEF.md
# Bimodal Insertion Recency-Stack Set

This block keeps the replacement state of a single set in a set-associative cache. It holds a full recency order over the ways, from the most recently used (MRU) way to the least recently used (LRU) way. Each way carries a recency rank: rank 0 is MRU and rank WAYS-1 is LRU. A hit promotes the hit way to MRU. On a miss the block names the victim way, which is always the LRU way. The fill request that follows places the new line at MRU or leaves it at LRU.

The placement is chosen per fill by a two-bit mode. Conventional mode always inserts at MRU. LRU-insertion mode leaves the new line at the LRU end, so a line that is never reused is the next to go and does not push older, useful lines out. Bimodal mode mostly behaves like LRU-insertion, but about one fill in thirty-two goes to MRU. An internal 16-bit LFSR decides which fills those are. The surrounding cache controller owns the tags, the data, and the choice of mode.

Requests are single-cycle pulses with no back-pressure: the block accepts every hit or fill in the cycle it is presented, and the updated order is visible one clock later. Hit and fill may not be requested together. If both are present, the fill wins.

Top module: `bip_recency_set`

## Requirements
- R1: After reset, way i holds rank i: way 0 is MRU, way WAYS-1 is LRU, and victim_way reads WAYS-1.
- R2: The ranks are always a permutation of 0..WAYS-1, and victim_way always names the way whose rank is WAYS-1.
- R3: A fill with fill_mode 2'b00 (conventional), or with the reserved code 2'b11, moves the victim way to rank 0. Every other way moves one rank toward LRU.
- R4: A fill with fill_mode 2'b01 (LRU-insertion) leaves all ranks unchanged, so the filled way stays the victim.
- R5: A fill with fill_mode 2'b10 (bimodal) behaves as R3 when the low 5 bits of the internal LFSR are all zero before the fill, and as R4 otherwise.
  - The LFSR is 16 bits wide and resets to 16'hACE1.
  - Each step shifts it left by one and feeds bit15^bit13^bit12^bit10 into bit 0.
  - It steps once per bimodal fill and at no other time.
- R6: A hit (no fill in the same cycle) moves hit_way to rank 0. Each way with a smaller rank moves one step toward LRU, and the remaining ways keep their ranks. This holds for any fill_mode value.
- R7: A hit on the way that is already MRU leaves every rank unchanged.
- R8: When hit_valid and fill_valid are both high, only the fill is applied and the hit is ignored.
- R9: In a cycle with neither request, all ranks hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hit_valid | input | 1 | Hit on hit_way this cycle |
| hit_way | input | $clog2(WAYS) | Way that hit |
| fill_valid | input | 1 | Fill into the current victim way this cycle |
| fill_mode | input | 2 | Insertion mode: 00 conventional, 01 LRU-insertion, 10 bimodal, 11 treated as conventional |
| victim_way | output | $clog2(WAYS) | Way at the LRU position |
| way_rank | output | WAYS*$clog2(WAYS) | Rank of way i in bits [i*$clog2(WAYS) +: $clog2(WAYS)] |

## Verification
The hit-promotion property assumes that fill_valid is low. The stimulus issues plain hits only with the fill deasserted, and raises both requests together only in the cases aimed at R8. The properties also assume that reset is applied before the first request. The bench holds rst_n low for several clocks, and every request is driven on the falling edge, so the properties see one settled request per rising edge. A behavioural order queue and its own LFSR are enough to predict every bimodal outcome, so the random mix of modes can be checked exactly.

// File: rtl/bip_pkg.sv
package bip_pkg;
  typedef enum logic [1:0] {
    INS_MRU     = 2'b00,
    INS_LRU     = 2'b01,
    INS_BIMODAL = 2'b10,
    INS_RSVD    = 2'b11
  } ins_mode_e;

  localparam int unsigned LFSR_W   = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
  localparam int unsigned THR_BITS = 5;
endpackage

// File: rtl/bip_throttle.sv
module bip_throttle
  import bip_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic take_mru
);
  logic [LFSR_W-1:0] lfsr_q;
  logic              fb;

  assign fb       = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];
  assign take_mru = (lfsr_q[THR_BITS-1:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lfsr_q <= LFSR_SEED;
    else if (step) lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
  end
endmodule

// File: rtl/bip_victim_find.sv
module bip_victim_find #(
  parameter int unsigned WAYS = 8,
  localparam int unsigned IDXW = $clog2(WAYS)
) (
  input  logic [WAYS*IDXW-1:0] rank,
  output logic [IDXW-1:0]      victim
);
  always_comb begin
    victim = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (rank[i*IDXW +: IDXW] == IDXW'(WAYS-1)) victim = IDXW'(i);
    end
  end
endmodule

// File: rtl/bip_rank_update.sv
module bip_rank_update #(
  parameter int unsigned WAYS = 8,
  localparam int unsigned IDXW = $clog2(WAYS)
) (
  input  logic [WAYS*IDXW-1:0] rank_q,
  input  logic                 promote_en,
  input  logic [IDXW-1:0]      promote_way,
  output logic [WAYS*IDXW-1:0] rank_d
);
  logic [IDXW-1:0] sel_rank;

  assign sel_rank = rank_q[promote_way*IDXW +: IDXW];

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic [IDXW-1:0] cur;
    assign cur = rank_q[g*IDXW +: IDXW];
    always_comb begin
      if (!promote_en)                     rank_d[g*IDXW +: IDXW] = cur;
      else if (promote_way == IDXW'(g))    rank_d[g*IDXW +: IDXW] = '0;
      else if (cur < sel_rank)             rank_d[g*IDXW +: IDXW] = cur + 1'b1;
      else                                 rank_d[g*IDXW +: IDXW] = cur;
    end
  end
endmodule

// File: rtl/bip_recency_set.sv
module bip_recency_set
  import bip_pkg::*;
#(
  parameter int unsigned WAYS = 8,
  localparam int unsigned IDXW = $clog2(WAYS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hit_valid,
  input  logic [IDXW-1:0]      hit_way,
  input  logic                 fill_valid,
  input  logic [1:0]           fill_mode,
  output logic [IDXW-1:0]      victim_way,
  output logic [WAYS*IDXW-1:0] way_rank
);
  ins_mode_e           mode;
  logic                take_mru;
  logic                lfsr_step;
  logic                promote_en;
  logic [IDXW-1:0]     promote_way;
  logic [WAYS*IDXW-1:0] rank_q, rank_d;

  assign mode      = ins_mode_e'(fill_mode);
  assign lfsr_step = fill_valid && (mode == INS_BIMODAL);

  bip_throttle u_thr (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (lfsr_step),
    .take_mru (take_mru)
  );

  bip_victim_find #(.WAYS(WAYS)) u_vic (
    .rank   (rank_q),
    .victim (victim_way)
  );

  always_comb begin
    promote_en  = 1'b0;
    promote_way = hit_way;
    if (fill_valid) begin
      promote_way = victim_way;
      unique case (mode)
        INS_MRU, INS_RSVD: promote_en = 1'b1;
        INS_LRU:           promote_en = 1'b0;
        INS_BIMODAL:       promote_en = take_mru;
      endcase
    end else if (hit_valid) begin
      promote_en = 1'b1;
    end
  end

  bip_rank_update #(.WAYS(WAYS)) u_upd (
    .rank_q      (rank_q),
    .promote_en  (promote_en),
    .promote_way (promote_way),
    .rank_d      (rank_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WAYS; i++) rank_q[i*IDXW +: IDXW] <= IDXW'(i);
    end else begin
      rank_q <= rank_d;
    end
  end

  assign way_rank = rank_q;
endmodule

// File: rtl/bip_recency_set_chk.sv
module bip_recency_set_chk #(
  parameter int unsigned WAYS = 8,
  localparam int unsigned IDXW = $clog2(WAYS)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 hit_valid,
  input logic [IDXW-1:0]      hit_way,
  input logic                 fill_valid,
  input logic [1:0]           fill_mode,
  input logic [IDXW-1:0]      victim_way,
  input logic [WAYS*IDXW-1:0] way_rank
);
  function automatic logic [IDXW-1:0] rk(input logic [WAYS*IDXW-1:0] v,
                                         input logic [IDXW-1:0] w);
    return v[w*IDXW +: IDXW];
  endfunction

  // R2: victim is the LRU way
  a_r2_victim_is_lru: assert property (@(posedge clk) disable iff (!rst_n)
    rk(way_rank, victim_way) == IDXW'(WAYS-1));

  // R2: each rank is held by exactly one way
  for (genvar r = 0; r < WAYS; r++) begin : g_perm
    logic [WAYS-1:0] holders;
    always_comb
      for (int i = 0; i < WAYS; i++)
        holders[i] = (way_rank[i*IDXW +: IDXW] == IDXW'(r));
    a_r2_unique_rank: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(holders) == 1);
  end

  // R3: conventional or reserved fill sends victim to MRU
  a_r3_conv_mru: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && (fill_mode == 2'b00 || fill_mode == 2'b11))
      |=> rk(way_rank, $past(victim_way)) == '0);

  // R4: LRU-insertion fill leaves the order alone
  a_r4_lru_insert_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_mode == 2'b01) |=> $stable(way_rank));

  // R5: bimodal fill either holds or sends victim to MRU
  a_r5_bimodal_choice: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && fill_mode == 2'b10)
      |=> ($stable(way_rank) || rk(way_rank, $past(victim_way)) == '0));

  // R6: a lone hit promotes the hit way
  a_r6_hit_mru: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !fill_valid) |=> rk(way_rank, $past(hit_way)) == '0);

  // R7: a hit on the MRU way changes nothing
  a_r7_hit_mru_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_valid && !fill_valid && rk(way_rank, hit_way) == '0) |=> $stable(way_rank));

  // R9: idle cycles hold state
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_valid && !fill_valid) |=> $stable(way_rank));
endmodule

bind bip_recency_set bip_recency_set_chk #(.WAYS(WAYS)) u_chk (.*);

// File: tb/bip_recency_set_tb.sv
module bip_recency_set_tb;
  localparam int WAYS = 8;
  localparam int IDXW = $clog2(WAYS);

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 hit_valid = 1'b0;
  logic [IDXW-1:0]      hit_way = '0;
  logic                 fill_valid = 1'b0;
  logic [1:0]           fill_mode = 2'b00;
  logic [IDXW-1:0]      victim_way;
  logic [WAYS*IDXW-1:0] way_rank;

  int n_checks = 0;
  int n_fails  = 0;
  int stk[$];
  bit [15:0] m_lfsr;
  int n_bim_mru = 0;

  always #2.5 clk = ~clk;

  bip_recency_set #(.WAYS(WAYS)) u_dut (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_way(hit_way),
    .fill_valid(fill_valid), .fill_mode(fill_mode),
    .victim_way(victim_way), .way_rank(way_rank)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
  endtask

  task automatic model_promote(input int w);
    foreach (stk[i]) if (stk[i] == w) begin stk.delete(i); break; end
    stk.push_front(w);
  endtask

  task automatic compare(input string tag);
    n_checks++;
    if (int'(victim_way) != stk[WAYS-1]) begin
      n_fails++;
      $display("FAIL %s victim_way actual=%0d expected=%0d", tag, victim_way, stk[WAYS-1]);
    end
    for (int p = 0; p < WAYS; p++) begin
      int w = stk[p];
      n_checks++;
      if (int'(way_rank[w*IDXW +: IDXW]) != p) begin
        n_fails++;
        $display("FAIL %s rank of way %0d actual=%0d expected=%0d",
                 tag, w, way_rank[w*IDXW +: IDXW], p);
      end
    end
  endtask

  task automatic step(input bit hv, input int hw, input bit fv, input bit [1:0] fm,
                      input string tag);
    @(negedge clk);
    hit_valid = hv; hit_way = IDXW'(hw); fill_valid = fv; fill_mode = fm;
    if (fv) begin
      int vic = stk[WAYS-1];
      case (fm)
        2'b00, 2'b11: model_promote(vic);
        2'b01: ;
        2'b10: begin
          if (m_lfsr[4:0] == 5'd0) begin model_promote(vic); n_bim_mru++; end
          m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
        end
      endcase
    end else if (hv) begin
      model_promote(hw);
    end
    @(posedge clk);
    #1;
    hit_valid = 1'b0; fill_valid = 1'b0;
    compare(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < WAYS; i++) stk.push_back(i);
    m_lfsr = 16'hACE1;
    repeat (4) @(posedge clk);
    #1 compare("R1");
    @(negedge clk) rst_n = 1'b1;
    #1 compare("R1");

    // R9: idle holds
    for (int k = 0; k < 3; k++) step(0, 0, 0, 2'b00, "R9");

    // R6: hits on various ways, R7: hit on MRU
    step(1, 5, 0, 2'b00, "R6");
    step(1, 2, 0, 2'b01, "R6");
    step(1, 7, 0, 2'b10, "R6");
    step(1, 7, 0, 2'b00, "R7");
    step(1, 0, 0, 2'b00, "R6");

    // R3: conventional fills, reserved code too
    for (int k = 0; k < 4; k++) step(0, 0, 1, 2'b00, "R3");
    step(0, 0, 1, 2'b11, "R3");

    // R4: LRU-insertion, filled line stays victim until hit
    for (int k = 0; k < 3; k++) step(0, 0, 1, 2'b01, "R4");
    step(1, stk[WAYS-1], 0, 2'b00, "R6");

    // R8: fill and hit together
    step(1, 3, 1, 2'b00, "R8");
    step(1, stk[WAYS-1], 1, 2'b01, "R8");
    step(1, 1, 1, 2'b10, "R8");

    // R5: long bimodal run interleaved with other traffic (LFSR must not step)
    for (int k = 0; k < 800; k++) begin
      step(0, 0, 1, 2'b10, "R5");
      if (k % 7 == 3) step(0, 0, 1, 2'b00, "R5");
      if (k % 11 == 5) step(1, k % WAYS, 0, 2'b10, "R5");
    end
    n_checks++;
    if (n_bim_mru == 0) begin
      n_fails++;
      $display("FAIL R5 bimodal MRU fills actual=%0d expected=>0", n_bim_mru);
    end

    // R2: random mix
    for (int k = 0; k < 3000; k++) begin
      int sel = $urandom_range(0, 9);
      if (sel < 4)      step(1, $urandom_range(0, WAYS-1), 0, 2'($urandom_range(0,3)), "R2");
      else if (sel < 9) step(0, 0, 1, 2'($urandom_range(0, 3)), "R2");
      else              step($urandom_range(0,1) == 1, $urandom_range(0, WAYS-1), 1,
                             2'($urandom_range(0, 3)), "R8");
    end

    summary();
    $finish;
  end
endmodule